// File: doc/BRIEF.md
# Row Retirement Column Sweeper

When a DRAM error is reported, every page that maps to the failing DRAM row has to be taken out of service. The row is fixed by the error address, but the column bits are not. This sequencer walks every value of the column field, one value at a time. For each value it sends the rewritten address to an external address translator. If translation succeeds, it asks an external page tracker whether the resulting page is online and whether it is already poisoned. Only a page that is online and not yet poisoned gets a retire request, and that request carries the page frame number.

All external exchanges use valid/ready handshakes. The block holds one sweep at a time. A mode input selects whether sweeping applies at all. When sweeping is not selected, an accepted start completes at once and no external traffic is generated.

Top module: `row_retire_sweeper`

## Requirements
- R1: An accepted sweep issues exactly 32 translation requests, one for each column value, in ascending order from 0 to 31.
- R2: Each translation request carries the start address with bits 5:1 replaced by the current column value; every other bit equals the start address.
- R3: A translation response with its error flag set produces no page query and no retire request for that column, and the sweep continues with the next column.
- R4: The page frame number sent on the page query and the retire request equals the translated physical address shifted right by PAGE_SHIFT bits (default 12).
- R5: A page reported as not online receives no retire request.
- R6: A page reported as already poisoned receives no retire request.
- R7: A retire request is issued once for each column whose translation succeeded and whose page is online and not poisoned, in column order.
- R8: When hetero_mode is 0, an accepted start raises done in the cycle after acceptance and produces no translation, query or retire traffic.
- R9: done is a single-cycle pulse raised after the last column finishes. busy is high from the cycle after acceptance through the done cycle and low afterwards.
- R10: start_ready is low while busy is high, and a start_valid presented during a sweep is ignored.
- R11: Every request valid stays high with a stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hetero_mode | input | 1 | 1 enables the column sweep; 0 makes a start a no-op |
| start_valid | input | 1 | Error report present |
| start_ready | output | 1 | Block is idle and takes a report |
| start_addr | input | ADDR_W | DRAM error address |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle completion pulse |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translator accepts request |
| xl_req_addr | output | ADDR_W | Address with column substituted |
| xl_rsp_valid | input | 1 | Translation result valid |
| xl_rsp_ready | output | 1 | Block accepts result |
| xl_rsp_err | input | 1 | Translation failed |
| xl_rsp_pa | input | PA_W | Translated physical address |
| pq_req_valid | output | 1 | Page status query valid |
| pq_req_ready | input | 1 | Tracker accepts query |
| pq_req_pfn | output | PA_W-PAGE_SHIFT | Page frame number queried |
| pq_rsp_valid | input | 1 | Status answer valid |
| pq_rsp_ready | output | 1 | Block accepts answer |
| pq_rsp_online | input | 1 | Page is online |
| pq_rsp_poisoned | input | 1 | Page is already poisoned |
| rt_req_valid | output | 1 | Retire request valid |
| rt_req_ready | input | 1 | Tracker accepts retire |
| rt_req_pfn | output | PA_W-PAGE_SHIFT | Page frame number to retire |

## Verification
Each request holds until its ready is seen, so most results have no fixed cycle. The responders wait for each request valid, then compare its payload against the next entry in per-interface expected queues. Those queues are filled from the masks before the start. done is the exception: with sweeping off, it must appear at the first falling edge after the accepting edge. In a sweep, done is polled at falling edges and must be gone, with busy low, at the very next falling edge. After done, every expected queue must be empty, and any request that arrives with an empty queue counts as an error.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        SW_IDLE = 3'd0,
        SW_XREQ = 3'd1,
        SW_XRSP = 3'd2,
        SW_QREQ = 3'd3,
        SW_QRSP = 3'd4,
        SW_RET  = 3'd5,
        SW_STEP = 3'd6,
        SW_FIN  = 3'd7
    } sweep_state_e;

    typedef struct packed {
        logic xl_ok;
        logic online;
        logic poisoned;
    } page_verdict_t;

    function automatic logic verdict_retire(input page_verdict_t v);
        return v.xl_ok && v.online && !v.poisoned;
    endfunction

endpackage

// File: rtl/rrs_col_ctr.sv
module rrs_col_ctr #(
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [COL_W-1:0] col,
    output logic             last
);
    localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            col <= '0;
        end else if (inc) begin
            col <= col + 1'b1;
        end
    end

    assign last = (col == COL_MAX);

    // R1: the column moves up by exactly one per step
    p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (col == $past(col) + 1'b1));

    // R1: every sweep starts from column zero
    p_col_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (col == '0));

endmodule

// File: rtl/rrs_addr_merge.sv
module rrs_addr_merge #(
    parameter int ADDR_W  = 28,
    parameter int COL_LSB = 1,
    parameter int COL_W   = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] COL_MASK =
        ADDR_W'({COL_W{1'b1}}) << COL_LSB;

    always_comb begin
        addr = (base & ~COL_MASK) | (ADDR_W'(col) << COL_LSB);
    end

endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
    import rrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hetero_mode,
    input  logic start_valid,
    output logic start_ready,
    output logic busy,
    output logic done,
    output logic xl_req_valid,
    input  logic xl_req_ready,
    input  logic xl_rsp_valid,
    output logic xl_rsp_ready,
    input  logic xl_rsp_err,
    output logic pq_req_valid,
    input  logic pq_req_ready,
    input  logic pq_rsp_valid,
    output logic pq_rsp_ready,
    input  logic pq_rsp_online,
    input  logic pq_rsp_poisoned,
    output logic rt_req_valid,
    input  logic rt_req_ready,
    input  logic col_last,
    output logic col_clr,
    output logic col_inc,
    output logic base_load,
    output logic pfn_load
);
    sweep_state_e  state, state_nx;
    page_verdict_t verdict;

    always_comb begin
        verdict.xl_ok    = 1'b1;
        verdict.online   = pq_rsp_online;
        verdict.poisoned = pq_rsp_poisoned;
    end

    always_comb begin
        state_nx  = state;
        col_clr   = 1'b0;
        col_inc   = 1'b0;
        base_load = 1'b0;
        pfn_load  = 1'b0;
        unique case (state)
            SW_IDLE: if (start_valid) begin
                if (hetero_mode) begin
                    state_nx  = SW_XREQ;
                    col_clr   = 1'b1;
                    base_load = 1'b1;
                end else begin
                    state_nx  = SW_FIN;
                end
            end
            SW_XREQ: if (xl_req_ready) state_nx = SW_XRSP;
            SW_XRSP: if (xl_rsp_valid) begin
                if (xl_rsp_err) begin
                    state_nx = SW_STEP;
                end else begin
                    state_nx = SW_QREQ;
                    pfn_load = 1'b1;
                end
            end
            SW_QREQ: if (pq_req_ready) state_nx = SW_QRSP;
            SW_QRSP: if (pq_rsp_valid) begin
                state_nx = verdict_retire(verdict) ? SW_RET : SW_STEP;
            end
            SW_RET:  if (rt_req_ready) state_nx = SW_STEP;
            SW_STEP: begin
                if (col_last) begin
                    state_nx = SW_FIN;
                end else begin
                    state_nx = SW_XREQ;
                    col_inc  = 1'b1;
                end
            end
            SW_FIN:  state_nx = SW_IDLE;
            default: state_nx = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SW_IDLE;
        else     state <= state_nx;
    end

    assign start_ready  = (state == SW_IDLE);
    assign busy         = (state != SW_IDLE);
    assign done         = (state == SW_FIN);
    assign xl_req_valid = (state == SW_XREQ);
    assign xl_rsp_ready = (state == SW_XRSP);
    assign pq_req_valid = (state == SW_QREQ);
    assign pq_rsp_ready = (state == SW_QRSP);
    assign rt_req_valid = (state == SW_RET);

    // R8: a start with sweeping off finishes on the next cycle with no traffic
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_ready && !hetero_mode) |=> (done && !xl_req_valid));

    // R9: done lasts one cycle and the block is idle right after
    p_fin_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R10: busy only rises from an offered start
    p_start_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_valid));

    // R3: a failed translation leads to neither a query nor a retire
    p_err_skip_r3: assert property (@(posedge clk) disable iff (rst)
        (xl_rsp_valid && xl_rsp_ready && xl_rsp_err) |=> (!pq_req_valid && !rt_req_valid));

    // R7 (with R5, R6): a retire follows only an online, unpoisoned answer
    p_ret_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rt_req_valid) |-> $past(pq_rsp_valid && pq_rsp_ready &&
                                      pq_rsp_online && !pq_rsp_poisoned));

    // R11: requests are not withdrawn before acceptance
    p_xl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (xl_req_valid && !xl_req_ready) |=> xl_req_valid);

    p_pq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (pq_req_valid && !pq_req_ready) |=> pq_req_valid);

endmodule

// File: rtl/row_retire_sweeper.sv
module row_retire_sweeper #(
    parameter int ADDR_W     = 28,
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int COL_LSB    = 1,
    parameter int COL_W      = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hetero_mode,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [ADDR_W-1:0]          start_addr,
    output logic                       busy,
    output logic                       done,
    output logic                       xl_req_valid,
    input  logic                       xl_req_ready,
    output logic [ADDR_W-1:0]          xl_req_addr,
    input  logic                       xl_rsp_valid,
    output logic                       xl_rsp_ready,
    input  logic                       xl_rsp_err,
    input  logic [PA_W-1:0]            xl_rsp_pa,
    output logic                       pq_req_valid,
    input  logic                       pq_req_ready,
    output logic [PA_W-PAGE_SHIFT-1:0] pq_req_pfn,
    input  logic                       pq_rsp_valid,
    output logic                       pq_rsp_ready,
    input  logic                       pq_rsp_online,
    input  logic                       pq_rsp_poisoned,
    output logic                       rt_req_valid,
    input  logic                       rt_req_ready,
    output logic [PA_W-PAGE_SHIFT-1:0] rt_req_pfn
);
    localparam int PFN_W = PA_W - PAGE_SHIFT;

    logic [ADDR_W-1:0] base_q;
    logic [PFN_W-1:0]  pfn_q;
    logic [COL_W-1:0]  col;
    logic              col_last, col_clr, col_inc, base_load, pfn_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pfn_q  <= '0;
        end else begin
            if (base_load) base_q <= start_addr;
            if (pfn_load)  pfn_q  <= PFN_W'(xl_rsp_pa >> PAGE_SHIFT);
        end
    end

    rrs_col_ctr #(.COL_W(COL_W)) u_col (
        .clk  (clk),
        .rst  (rst),
        .clr  (col_clr),
        .inc  (col_inc),
        .col  (col),
        .last (col_last)
    );

    rrs_addr_merge #(.ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W)) u_merge (
        .base (base_q),
        .col  (col),
        .addr (xl_req_addr)
    );

    rrs_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .hetero_mode     (hetero_mode),
        .start_valid     (start_valid),
        .start_ready     (start_ready),
        .busy            (busy),
        .done            (done),
        .xl_req_valid    (xl_req_valid),
        .xl_req_ready    (xl_req_ready),
        .xl_rsp_valid    (xl_rsp_valid),
        .xl_rsp_ready    (xl_rsp_ready),
        .xl_rsp_err      (xl_rsp_err),
        .pq_req_valid    (pq_req_valid),
        .pq_req_ready    (pq_req_ready),
        .pq_rsp_valid    (pq_rsp_valid),
        .pq_rsp_ready    (pq_rsp_ready),
        .pq_rsp_online   (pq_rsp_online),
        .pq_rsp_poisoned (pq_rsp_poisoned),
        .rt_req_valid    (rt_req_valid),
        .rt_req_ready    (rt_req_ready),
        .col_last        (col_last),
        .col_clr         (col_clr),
        .col_inc         (col_inc),
        .base_load       (base_load),
        .pfn_load        (pfn_load)
    );

    assign pq_req_pfn = pfn_q;
    assign rt_req_pfn = pfn_q;

    // R11: translation address holds while waiting for ready
    p_xl_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (xl_req_valid && !xl_req_ready) |=> $stable(xl_req_addr));

    // R11: retire payload holds while waiting for ready
    p_rt_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rt_req_valid && !rt_req_ready) |=> (rt_req_valid && $stable(rt_req_pfn)));

    // R4: the queried frame is the accepted address shifted by the page size
    p_pfn_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pq_req_valid) |-> (pq_req_pfn == PFN_W'($past(xl_rsp_pa) >> PAGE_SHIFT)));

endmodule

// File: tb/row_retire_sweeper_tb.sv
`timescale 1ns/1ps
module row_retire_sweeper_tb_top;

    localparam int ADDR_W = 28;
    localparam int PA_W   = 48;
    localparam int PFN_W  = 36;

    logic              clk = 1'b0;
    logic              rst;
    logic              hetero_mode, start_valid, start_ready, busy, done;
    logic [ADDR_W-1:0] start_addr;
    logic              xl_req_valid, xl_req_ready, xl_rsp_valid, xl_rsp_ready, xl_rsp_err;
    logic [ADDR_W-1:0] xl_req_addr;
    logic [PA_W-1:0]   xl_rsp_pa;
    logic              pq_req_valid, pq_req_ready, pq_rsp_valid, pq_rsp_ready;
    logic              pq_rsp_online, pq_rsp_poisoned;
    logic [PFN_W-1:0]  pq_req_pfn, rt_req_pfn;
    logic              rt_req_valid, rt_req_ready;

    always #10 clk = ~clk;

    row_retire_sweeper dut_i (
        .clk(clk), .rst(rst), .hetero_mode(hetero_mode),
        .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
        .busy(busy), .done(done),
        .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready), .xl_req_addr(xl_req_addr),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready), .xl_rsp_err(xl_rsp_err),
        .xl_rsp_pa(xl_rsp_pa),
        .pq_req_valid(pq_req_valid), .pq_req_ready(pq_req_ready), .pq_req_pfn(pq_req_pfn),
        .pq_rsp_valid(pq_rsp_valid), .pq_rsp_ready(pq_rsp_ready),
        .pq_rsp_online(pq_rsp_online), .pq_rsp_poisoned(pq_rsp_poisoned),
        .rt_req_valid(rt_req_valid), .rt_req_ready(rt_req_ready), .rt_req_pfn(rt_req_pfn)
    );

    int checks = 0;
    int errors = 0;
    int lat = 0;
    logic [31:0] err_mask, off_mask, poi_mask;
    logic [4:0]  last_col;

    logic [ADDR_W-1:0] exp_xl[$];
    logic [PFN_W-1:0]  exp_pq[$];
    logic [PFN_W-1:0]  exp_rt[$];

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // translator model: physical address = request address << 12 | 0x5A7
    initial begin : xl_model
        logic [ADDR_W-1:0] cap, e;
        xl_req_ready = 0; xl_rsp_valid = 0; xl_rsp_err = 0; xl_rsp_pa = '0;
        forever begin
            @(negedge clk);
            if (!rst && xl_req_valid) begin
                repeat (lat) @(negedge clk);
                check(xl_req_valid === 1'b1, "R11 xl valid held", 64'(xl_req_valid), 64'd1);
                if (exp_xl.size() == 0) begin
                    check(1'b0, "R8 R10 unexpected translation", 64'(xl_req_addr), 64'd0);
                end else begin
                    e = exp_xl.pop_front();
                    check(xl_req_addr === e, "R1 R2 translation address", 64'(xl_req_addr), 64'(e));
                end
                cap = xl_req_addr;
                xl_req_ready = 1; @(negedge clk); xl_req_ready = 0;
                repeat (lat) @(negedge clk);
                last_col     = cap[5:1];
                xl_rsp_valid = 1;
                xl_rsp_err   = err_mask[cap[5:1]];
                xl_rsp_pa    = (PA_W'(cap) << 12) | 48'h5A7;
                @(negedge clk);
                xl_rsp_valid = 0; xl_rsp_err = 0;
            end
        end
    end

    // page status model, driven by the masks for the last translated column
    initial begin : pq_model
        logic [PFN_W-1:0] e;
        pq_req_ready = 0; pq_rsp_valid = 0; pq_rsp_online = 0; pq_rsp_poisoned = 0;
        forever begin
            @(negedge clk);
            if (!rst && pq_req_valid) begin
                repeat (lat) @(negedge clk);
                if (exp_pq.size() == 0) begin
                    check(1'b0, "R3 unexpected page query", 64'(pq_req_pfn), 64'd0);
                end else begin
                    e = exp_pq.pop_front();
                    check(pq_req_pfn === e, "R4 query frame number", 64'(pq_req_pfn), 64'(e));
                end
                pq_req_ready = 1; @(negedge clk); pq_req_ready = 0;
                repeat (lat) @(negedge clk);
                pq_rsp_valid    = 1;
                pq_rsp_online   = !off_mask[last_col];
                pq_rsp_poisoned = poi_mask[last_col];
                @(negedge clk);
                pq_rsp_valid = 0; pq_rsp_online = 0; pq_rsp_poisoned = 0;
            end
        end
    end

    // retire monitor: scoreboard pop and compare
    initial begin : rt_model
        logic [PFN_W-1:0] e;
        rt_req_ready = 0;
        forever begin
            @(negedge clk);
            if (!rst && rt_req_valid) begin
                repeat (lat) @(negedge clk);
                if (exp_rt.size() == 0) begin
                    check(1'b0, "R5 R6 unexpected retire", 64'(rt_req_pfn), 64'd0);
                end else begin
                    e = exp_rt.pop_front();
                    check(rt_req_pfn === e, "R7 retire frame number", 64'(rt_req_pfn), 64'(e));
                end
                rt_req_ready = 1; @(negedge clk); rt_req_ready = 0;
            end
        end
    end

    task automatic run_sweep(input logic [ADDR_W-1:0] base, input logic het,
                             input logic [31:0] em, input logic [31:0] om,
                             input logic [31:0] pm, input logic poke);
        logic [ADDR_W-1:0] a;
        int n;
        err_mask = em; off_mask = om; poi_mask = pm;
        if (het) begin
            for (int c = 0; c < 32; c++) begin
                a = (base & ~28'h000003E) | (ADDR_W'(c) << 1);
                exp_xl.push_back(a);
                if (!em[c]) begin
                    exp_pq.push_back(PFN_W'(({20'h0, a, 12'h5A7}) >> 12));
                    if (!om[c] && !pm[c]) exp_rt.push_back(PFN_W'(a));
                end
            end
        end
        @(negedge clk);
        check(start_ready === 1'b1, "R10 ready when idle", 64'(start_ready), 64'd1);
        hetero_mode = het; start_addr = base; start_valid = 1;
        @(negedge clk);
        start_valid = 0;
        if (!het) begin
            check(done === 1'b1 && busy === 1'b1, "R8 immediate done", 64'(done), 64'd1);
            @(negedge clk);
            check(done === 1'b0 && busy === 1'b0, "R9 idle after done", 64'(busy), 64'd0);
        end else begin
            check(done === 1'b0 && busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
            if (poke) begin
                repeat (5) @(negedge clk);
                check(start_ready === 1'b0, "R10 not ready while busy", 64'(start_ready), 64'd0);
                start_addr = 28'h0000000; start_valid = 1;
                @(negedge clk);
                start_valid = 0;
            end
            n = 0;
            while (done !== 1'b1 && n < 20000) begin
                @(negedge clk); n++;
            end
            check(done === 1'b1, "R9 done raised", 64'(done), 64'd1);
            @(negedge clk);
            check(done === 1'b0 && busy === 1'b0 && start_ready === 1'b1,
                  "R9 single pulse then idle", 64'({done, busy}), 64'd0);
        end
        repeat (4) @(negedge clk);
        check(exp_xl.size() == 0, "R1 all columns translated", 64'(exp_xl.size()), 64'd0);
        check(exp_pq.size() == 0, "R3 queries complete", 64'(exp_pq.size()), 64'd0);
        check(exp_rt.size() == 0, "R7 retires complete", 64'(exp_rt.size()), 64'd0);
        exp_xl.delete(); exp_pq.delete(); exp_rt.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        rst = 1; hetero_mode = 0; start_valid = 0; start_addr = '0;
        err_mask = '0; off_mask = '0; poi_mask = '0; last_col = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && start_ready === 1'b1,
              "R9 R10 reset state", 64'({busy, done, start_ready}), 64'd1);
        check(!xl_req_valid && !pq_req_valid && !rt_req_valid,
              "R11 no requests after reset", 64'({xl_req_valid, pq_req_valid, rt_req_valid}), 64'd0);

        lat = 0; // R7 every column retired
        run_sweep(28'hABCDEF1, 1'b1, 32'h0, 32'h0, 32'h0, 1'b0);
        lat = 1; // R3 R5 R6 mixed filtering, R10 poke during sweep
        run_sweep(28'h1234567, 1'b1, 32'h000000F1, 32'h0F000300, 32'h30C00006, 1'b1);
        lat = 2; // R3 every translation fails
        run_sweep(28'h7654320, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0);
        lat = 0; // R8 sweeping disabled
        run_sweep(28'h5555555, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0);
        lat = 0; // R2 column bits already set, R5 R6 patterns
        run_sweep(28'hFFFFFFF, 1'b1, 32'h0, 32'h55555555, 32'hAAAA0000, 1'b0);
        lat = 1; // R6 all poisoned
        run_sweep(28'h0000000, 1'b1, 32'h0, 32'h0, 32'hFFFFFFFF, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule